// File: doc/BRIEF.md
# Four-Mode Power State Sequencer

This block decides which of four power modes the device is in: Active, Power Save, Idle or Halt. Software leaves Active by setting request bits in a small control register. A separate control bit selects how the switch happens. When the bit is clear, a Power Save request takes effect at once. When it is set, any request waits until the processor signals that it has executed its wait instruction. Idle and Halt can only be entered in this deferred way.

Hardware wake events return the device to Active. A wake is either a pulse on any of the maskable wake lines or a non-maskable interrupt. Each wake is held in a latch until the interrupt controller acknowledges it. Every transition also depends on clock health. Entry to a low-power mode needs the slow clock to be good. Return to Active needs both the main oscillator and the PLL to be good. A transition that is blocked by a clock flag stays pending and fires as soon as the flag allows it. The wake only restores the clocks; program execution resumes later through the interrupt handler, which is outside this block.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, the mode output is Active (code 0), all control bits read back as 0, and no wake is pending.
- R2: Control bits are bit 0 = Power Save request, bit 1 = Idle request, bit 2 = Halt request and bit 3 = wait-before-switch. Mode codes are Active 0, Power Save 1, Idle 2, Halt 3. When bit 3 is 0 and bit 0 is 1, the mode becomes Power Save on the clock edge after the register write. Bits 1 and 2 and the wait strobe are ignored while bit 3 is 0.
- R3: When bit 3 is 1, Active is left only on an edge where the wait strobe is high and at least one request bit is set. Without the strobe the mode stays Active.
- R4: In deferred switching, the target mode is chosen by priority: Halt first, then Idle, then Power Save.
- R5: A pulse on any maskable wake line or on the NMI input sets the wake-pending flag on the next edge. The flag holds until an interrupt acknowledge clears it. A new event in the same cycle as an acknowledge wins, so the flag stays set.
- R6: In any low-power mode, a pending wake with the main-oscillator and PLL flags both high returns the mode to Active on the next edge.
- R7: The mode never enters Active while the main-oscillator flag or the PLL flag is low. The wake then completes on the first edge where both flags are high.
- R8: The mode never leaves Active while the slow-clock flag is low. A qualified request is held pending and is taken on the first edge with the flag high, even if the strobe has gone.
- R9: Re-entry into Active clears the three request bits. Bit 3 keeps its value.
- R10: In a low-power mode, register writes and the wait strobe do not change the mode. In Active, a pending wake or an acknowledge does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 4 | Control write data (bit map in R2) |
| wait_strobe | input | 1 | One-cycle pulse: processor executed wait |
| wake_in | input | NUM_WAKE | Maskable wake event pulses |
| nmi_in | input | 1 | Non-maskable interrupt pulse |
| int_ack | input | 1 | Interrupt acknowledge, clears pending wake |
| lf_ok | input | 1 | Slow clock stable |
| hf_ok | input | 1 | Main oscillator stable |
| pll_ok | input | 1 | PLL stable or disabled |
| ctl_q | output | 4 | Control register read-back |
| mode_o | output | 2 | Current power mode code |
| wake_pending | output | 1 | Latched wake event |

## Verification
The properties assume that the clock flags and the event inputs are synchronous and settled at each rising edge. They also assume that reset is applied before any event. They make no assumption about how often strobes or wakes come, so back-to-back events and acknowledges that meet an event in the same cycle are legal. The bench changes every input only just after a falling edge, and it keeps each strobe to a single cycle. It sweeps all sixteen control values with and without the strobe, every wake source, and every combination of the two fast-clock flags.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_PSAVE  = 2'd1,
    PM_IDLE   = 2'd2,
    PM_HALT   = 2'd3
  } pmode_e;

  localparam int CTL_W     = 4;
  localparam int BIT_PSAVE = 0;
  localparam int BIT_IDLE  = 1;
  localparam int BIT_HALT  = 2;
  localparam int BIT_WBSW  = 3;
endpackage

// File: rtl/pwr_wake_latch.sv
module pwr_wake_latch #(
  parameter int NUM_WAKE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAKE-1:0] wake_in,
  input  logic                nmi_in,
  input  logic                int_ack,
  output logic                pending
);
  logic event_now;
  assign event_now = (|wake_in) | nmi_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= (pending & ~int_ack) | event_now;
  end
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             clr_req,
  output logic [CTL_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (we) q <= wdata;
      if (clr_req) begin
        q[BIT_PSAVE] <= 1'b0;
        q[BIT_IDLE]  <= 1'b0;
        q[BIT_HALT]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl,
  input  logic             wait_strobe,
  input  logic             wake_pending,
  input  logic             lf_ok,
  input  logic             hf_ok,
  input  logic             pll_ok,
  output pmode_e           mode,
  output logic             go_active
);
  logic   cond_now;
  pmode_e cond_mode;
  logic   pend_q;
  pmode_e pend_mode_q;
  pmode_e sel_mode;
  logic   go_low;
  logic   in_active;

  always_comb begin
    cond_now  = 1'b0;
    cond_mode = PM_PSAVE;
    if (ctl[BIT_WBSW]) begin
      if (wait_strobe) begin
        if (ctl[BIT_HALT]) begin
          cond_now  = 1'b1;
          cond_mode = PM_HALT;
        end else if (ctl[BIT_IDLE]) begin
          cond_now  = 1'b1;
          cond_mode = PM_IDLE;
        end else if (ctl[BIT_PSAVE]) begin
          cond_now  = 1'b1;
          cond_mode = PM_PSAVE;
        end
      end
    end else if (ctl[BIT_PSAVE]) begin
      cond_now  = 1'b1;
      cond_mode = PM_PSAVE;
    end
  end

  assign in_active = (mode == PM_ACTIVE);
  assign sel_mode  = pend_q ? pend_mode_q : cond_mode;
  assign go_low    = in_active && (pend_q || cond_now) && lf_ok;
  assign go_active = !in_active && wake_pending && hf_ok && pll_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= PM_ACTIVE;
      pend_q      <= 1'b0;
      pend_mode_q <= PM_PSAVE;
    end else if (go_low) begin
      mode   <= sel_mode;
      pend_q <= 1'b0;
    end else if (go_active) begin
      mode <= PM_ACTIVE;
    end else if (in_active && cond_now && !pend_q) begin
      pend_q      <= 1'b1;
      pend_mode_q <= cond_mode;
    end
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_WAKE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [3:0]          ctl_wdata,
  input  logic                wait_strobe,
  input  logic [NUM_WAKE-1:0] wake_in,
  input  logic                nmi_in,
  input  logic                int_ack,
  input  logic                lf_ok,
  input  logic                hf_ok,
  input  logic                pll_ok,
  output logic [3:0]          ctl_q,
  output logic [1:0]          mode_o,
  output logic                wake_pending
);
  pmode_e mode;
  logic   go_active;

  pwr_wake_latch #(.NUM_WAKE(NUM_WAKE)) u_wake (
    .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .nmi_in(nmi_in),
    .int_ack(int_ack), .pending(wake_pending)
  );

  pwr_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .clr_req(go_active), .q(ctl_q)
  );

  pwr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .wait_strobe(wait_strobe),
    .wake_pending(wake_pending), .lf_ok(lf_ok), .hf_ok(hf_ok),
    .pll_ok(pll_ok), .mode(mode), .go_active(go_active)
  );

  assign mode_o = mode;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic [3:0] ctl_q,
  input logic       wake_pending,
  input logic       int_ack,
  input logic       lf_ok,
  input logic       hf_ok,
  input logic       pll_ok
);
  a_r7_no_active_without_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0 && !(hf_ok && pll_ok)) |=> mode_o == $past(mode_o));

  a_r8_no_sleep_without_slow_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !lf_ok) |=> mode_o == 2'd0);

  a_r6_wake_returns_active: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0 && wake_pending && hf_ok && pll_ok) |=> mode_o == 2'd0);

  a_r5_wake_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pending && !int_ack) |=> wake_pending);

  a_r9_requests_cleared_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0) |=> (mode_o != 2'd0 || ctl_q[2:0] == 3'b000));

  a_r10_low_power_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0 && !wake_pending) |=> $stable(mode_o));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .ctl_q(ctl_q),
  .wake_pending(wake_pending), .int_ack(int_ack), .lf_ok(lf_ok),
  .hf_ok(hf_ok), .pll_ok(pll_ok)
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_we;
  logic [3:0]    ctl_wdata;
  logic          wait_strobe;
  logic [NW-1:0] wake_in;
  logic          nmi_in;
  logic          int_ack;
  logic          lf_ok, hf_ok, pll_ok;
  logic [3:0]    ctl_q;
  logic [1:0]    mode_o;
  logic          wake_pending;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  pwr_mode_seq #(.NUM_WAKE(NW)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .wait_strobe(wait_strobe), .wake_in(wake_in), .nmi_in(nmi_in),
    .int_ack(int_ack), .lf_ok(lf_ok), .hf_ok(hf_ok), .pll_ok(pll_ok),
    .ctl_q(ctl_q), .mode_o(mode_o), .wake_pending(wake_pending)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; wait_strobe = 1'b0;
    wake_in = '0; nmi_in = 1'b0; int_ack = 1'b0;
    lf_ok = 1'b1; hf_ok = 1'b1; pll_ok = 1'b1;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic write_ctl(input logic [3:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    step();
    ctl_we = 1'b0;
  endtask

  task automatic enter_mode(input int m);
    write_ctl(4'b1000 | (4'b0001 << (m - 1)));
    wait_strobe = 1'b1;
    step();
    wait_strobe = 1'b0;
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 mode", int'(mode_o), 0);
    check("R1 ctl", int'(ctl_q), 0);
    check("R1 wake", int'(wake_pending), 0);

    // R2 R3 R4: sweep all control values with and without strobe
    for (int wd = 0; wd < 16; wd++) begin
      for (int s = 0; s < 2; s++) begin
        int exp;
        do_reset();
        write_ctl(wd[3:0]);
        wait_strobe = s[0];
        step();
        wait_strobe = 1'b0;
        if (wd[3]) exp = (s == 0) ? 0 : wd[2] ? 3 : wd[1] ? 2 : wd[0] ? 1 : 0;
        else       exp = wd[0] ? 1 : 0;
        check(wd[3] ? "R3 R4 deferred switch" : "R2 immediate switch", int'(mode_o), exp);
      end
    end

    // R5 R6: every wake source from every low-power mode
    for (int m = 1; m < 4; m++) begin
      for (int src = 0; src <= NW; src++) begin
        do_reset();
        enter_mode(m);
        check("R3 entered", int'(mode_o), m);
        if (src == NW) nmi_in = 1'b1; else wake_in[src] = 1'b1;
        step();
        nmi_in = 1'b0; wake_in = '0;
        check("R5 latched", int'(wake_pending), 1);
        step();
        check("R6 woke", int'(mode_o), 0);
        check("R9 req cleared", int'(ctl_q), 8);
        step();
        check("R5 held", int'(wake_pending), 1);
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
        check("R5 acked", int'(wake_pending), 0);
      end
    end

    // R7: all combinations of fast clock flags
    for (int c = 0; c < 4; c++) begin
      do_reset();
      enter_mode(2);
      hf_ok = c[0]; pll_ok = c[1];
      nmi_in = 1'b1;
      step();
      nmi_in = 1'b0;
      step();
      check("R7 gated wake", int'(mode_o), (c == 3) ? 0 : 2);
      hf_ok = 1'b1; pll_ok = 1'b1;
      step();
      check("R7 wake completes", int'(mode_o), 0);
    end

    // R8: slow clock low blocks entry, pending completes later
    do_reset();
    lf_ok = 1'b0;
    write_ctl(4'b1010);
    wait_strobe = 1'b1;
    step();
    wait_strobe = 1'b0;
    step(); step();
    check("R8 blocked", int'(mode_o), 0);
    lf_ok = 1'b1;
    step();
    check("R8 pending taken", int'(mode_o), 2);

    // R5: set and ack in the same cycle
    do_reset();
    wake_in[0] = 1'b1;
    step();
    check("R10 active ignores wake", int'(mode_o), 0);
    int_ack = 1'b1; wake_in[0] = 1'b1;
    step();
    int_ack = 1'b0; wake_in = '0;
    check("R5 set beats ack", int'(wake_pending), 1);
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    check("R10 ack in active", int'(mode_o), 0);

    // R10: writes and strobe ignored in low power
    do_reset();
    enter_mode(1);
    write_ctl(4'b1100);
    wait_strobe = 1'b1;
    step();
    wait_strobe = 1'b0;
    step();
    check("R10 low power holds", int'(mode_o), 1);
    check("R10 write stored", int'(ctl_q), 12);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule